// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block keeps track of which operating mode a CAN protocol controller is in: configuration, sleep, normal, loopback or snoop. Software programs it through a small register write port with two registers. The control register carries a soft-reset bit and an enable bit. The mode-select register carries one request bit each for sleep, loopback and snoop. The block reports the current mode as a set of status flags and as a decoded mode code. It drives a lock signal for the timing and threshold registers, and a one-cycle flush pulse that empties the transmit FIFO, the receive FIFO and the high-priority transmit buffer.

Most mode changes go through configuration mode. Software first clears the enable bit, then writes the mode-select register, then sets the enable bit again. Sleep and normal are the exception: they swap directly with a single mode-select write. Snoop does not have a flag of its own among the primary flags; it is shown as normal with the snoop flag also raised. Loopback is the mode in which none of the primary flags is set.

All ports carry plain control and status levels, so no valid/ready handshake applies. A write is taken on any clock edge where `reg_wr` is high. The block never stalls a write, so there is no back-pressure.

Top module: `can_mode_seq`

## Requirements
- R1: After hardware reset, and on the edge that captures a control write (address 0) with bit 0 (soft reset) set, the block is in configuration mode with the mode-select register cleared. A soft-reset write also raises `flush_pulse` for exactly one cycle. Soft reset takes priority over the enable bit (bit 1) written in the same word.
- R2: A control write with bit 0 clear and bit 1 (enable) clear puts the block in configuration mode, from any mode.
- R3: In configuration mode, writes to the mode-select register (address 1) are stored. Its bits are: bit 0 sleep, bit 1 loopback, bit 2 snoop.
- R4: A control write with the enable bit set, made in configuration mode, enters the requested mode: sleep bit alone gives sleep, loopback bit alone gives loopback, snoop bit alone gives snoop, and all bits clear gives normal.
- R5: If the mode-select register holds more than one set bit when the enable bit is written, the block stays in configuration mode.
- R6: In normal mode (not snoop), a mode-select write of exactly the sleep bit stores that value and moves straight to sleep. In sleep mode, a mode-select write of zero moves straight to normal. Neither path passes through configuration mode.
- R7: While enabled, any other mode-select write is ignored: neither the register nor the mode changes. A control write with enable set while already enabled is also ignored.
- R8: Status flags: `flag_config`, `flag_sleep` and `flag_normal` are mutually exclusive. Snoop raises both `flag_normal` and `flag_snoop`. Loopback raises none. `mode_code` decodes the flags with priority config, then sleep, then normal: 0 config, 1 sleep, 2 normal, 3 loopback, 4 snoop.
- R9: `cfg_lock` is high exactly when the block is outside configuration mode. `guard_wr_ok` is `guard_wr_req` gated by configuration mode.
- R10: Flags and mode code change on the clock edge that captures the causing write. They do not change in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select: 0 control, 1 mode select |
| reg_wdata | input | DATA_W | Write data |
| guard_wr_req | input | 1 | Write attempt to a timing/threshold register |
| guard_wr_ok | output | 1 | That write is permitted |
| cfg_lock | output | 1 | Timing/threshold registers locked |
| flush_pulse | output | 1 | One-cycle clear of TX FIFO, RX FIFO and priority buffer |
| flag_config | output | 1 | Configuration flag |
| flag_sleep | output | 1 | Sleep flag |
| flag_normal | output | 1 | Normal flag |
| flag_snoop | output | 1 | Snoop flag |
| mode_code | output | 3 | Decoded mode |
| msel_q | output | 3 | Current mode-select register contents |

## Verification
A wrong internal state shows up on the flags and on `mode_code` at the very next sample after the edge that captures a write. Each flag and the mode code come straight from the state register, with no pipeline in between. An illegal state such as two primary flags set, or snoop without normal, appears in the same cycle as the state. A wrongly accepted or rejected mode-select write is visible on `msel_q` one cycle later. A missed soft reset shows as a missing `flush_pulse` in the cycle after the write.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  localparam int SEL_W         = 3;
  localparam int CTL_RST_BIT   = 0;
  localparam int CTL_EN_BIT    = 1;
  localparam int SEL_SLEEP_BIT = 0;
  localparam int SEL_LOOP_BIT  = 1;
  localparam int SEL_SNOOP_BIT = 2;

  typedef enum logic [2:0] {
    MODE_CONFIG   = 3'd0,
    MODE_SLEEP    = 3'd1,
    MODE_NORMAL   = 3'd2,
    MODE_LOOPBACK = 3'd3,
    MODE_SNOOP    = 3'd4
  } mode_e;

  typedef struct packed {
    logic cfg;
    logic slp;
    logic nrm;
    logic snp;
  } flags_t;

  // Mode requested by a mode-select value; ambiguous requests keep configuration.
  function automatic mode_e target_mode(input logic [SEL_W-1:0] sel);
    int n;
    n = 0;
    for (int i = 0; i < SEL_W; i++) n += int'(sel[i]);
    if (n > 1)                   return MODE_CONFIG;
    else if (sel[SEL_SLEEP_BIT]) return MODE_SLEEP;
    else if (sel[SEL_LOOP_BIT])  return MODE_LOOPBACK;
    else if (sel[SEL_SNOOP_BIT]) return MODE_SNOOP;
    else                         return MODE_NORMAL;
  endfunction

endpackage

// File: rtl/cms_wr_decode.sv
module cms_wr_decode
  import can_mode_pkg::*;
#(
  parameter int ADDR_W   = 1,
  parameter int DATA_W   = 3,
  parameter int CTL_ADDR = 0,
  parameter int SEL_ADDR = 1
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              ctl_wr,
  output logic              sel_wr,
  output logic              soft_rst,
  output logic              en_bit,
  output logic [SEL_W-1:0]  sel_val
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);

  assign ctl_wr   = reg_wr && (reg_addr == CTL_A);
  assign sel_wr   = reg_wr && (reg_addr == SEL_A);
  assign soft_rst = reg_wdata[CTL_RST_BIT];
  assign en_bit   = reg_wdata[CTL_EN_BIT];
  assign sel_val  = reg_wdata[SEL_W-1:0];
endmodule

// File: rtl/cms_fsm.sv
module cms_fsm
  import can_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             sel_wr,
  input  logic             soft_rst,
  input  logic             en_bit,
  input  logic [SEL_W-1:0] sel_val,
  output flags_t           flags,
  output logic [SEL_W-1:0] sel_q,
  output logic             flush_q
);
  localparam logic [SEL_W-1:0] SLEEP_ONLY = SEL_W'(1) << SEL_SLEEP_BIT;

  mode_e            st_q, st_d;
  logic [SEL_W-1:0] sel_d;
  logic             flush_d;

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    flush_d = 1'b0;
    if (ctl_wr && soft_rst) begin
      st_d    = MODE_CONFIG;
      sel_d   = '0;
      flush_d = 1'b1;
    end else if (ctl_wr) begin
      if (!en_bit)                 st_d = MODE_CONFIG;
      else if (st_q == MODE_CONFIG) st_d = target_mode(sel_q);
    end else if (sel_wr) begin
      if (st_q == MODE_CONFIG) begin
        sel_d = sel_val;
      end else if (st_q == MODE_NORMAL && sel_val == SLEEP_ONLY) begin
        sel_d = sel_val;
        st_d  = MODE_SLEEP;
      end else if (st_q == MODE_SLEEP && sel_val == '0) begin
        sel_d = '0;
        st_d  = MODE_NORMAL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MODE_CONFIG;
      sel_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      flush_q <= flush_d;
    end
  end

  always_comb begin
    flags.cfg = (st_q == MODE_CONFIG);
    flags.slp = (st_q == MODE_SLEEP);
    flags.nrm = (st_q == MODE_NORMAL) || (st_q == MODE_SNOOP);
    flags.snp = (st_q == MODE_SNOOP);
  end
endmodule

// File: rtl/cms_decode.sv
module cms_decode
  import can_mode_pkg::*;
(
  input  flags_t     flags,
  output logic [2:0] code
);
  always_comb begin
    if (flags.cfg)      code = MODE_CONFIG;
    else if (flags.slp) code = MODE_SLEEP;
    else if (flags.nrm) code = flags.snp ? MODE_SNOOP : MODE_NORMAL;
    else                code = MODE_LOOPBACK;
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int ADDR_W   = 1,
  parameter int DATA_W   = 3,
  parameter int CTL_ADDR = 0,
  parameter int SEL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              guard_wr_req,
  output logic              guard_wr_ok,
  output logic              cfg_lock,
  output logic              flush_pulse,
  output logic              flag_config,
  output logic              flag_sleep,
  output logic              flag_normal,
  output logic              flag_snoop,
  output logic [2:0]        mode_code,
  output logic [2:0]        msel_q
);
  logic             ctl_wr, sel_wr, soft_rst, en_bit;
  logic [SEL_W-1:0] sel_val, sel_q;
  flags_t           flags;

  cms_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR), .SEL_ADDR(SEL_ADDR)
  ) u_wdec (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ctl_wr(ctl_wr), .sel_wr(sel_wr), .soft_rst(soft_rst),
    .en_bit(en_bit), .sel_val(sel_val)
  );

  cms_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .sel_wr(sel_wr),
    .soft_rst(soft_rst), .en_bit(en_bit), .sel_val(sel_val),
    .flags(flags), .sel_q(sel_q), .flush_q(flush_pulse)
  );

  cms_decode u_dec (.flags(flags), .code(mode_code));

  assign flag_config = flags.cfg;
  assign flag_sleep  = flags.slp;
  assign flag_normal = flags.nrm;
  assign flag_snoop  = flags.snp;
  assign cfg_lock    = ~flags.cfg;
  assign guard_wr_ok = guard_wr_req & flags.cfg;
  assign msel_q      = 3'(sel_q);
endmodule

// File: rtl/cms_checker.sv
module cms_checker #(
  parameter int ADDR_W   = 1,
  parameter int DATA_W   = 3,
  parameter int CTL_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              guard_wr_ok,
  input logic              cfg_lock,
  input logic              flush_pulse,
  input logic              flag_config,
  input logic              flag_sleep,
  input logic              flag_normal,
  input logic              flag_snoop,
  input logic [2:0]        mode_code,
  input logic [2:0]        msel_q
);
  logic srst_wr;
  assign srst_wr = reg_wr && (reg_addr == ADDR_W'(CTL_ADDR)) && reg_wdata[0];

  assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (flag_config && flush_pulse && msel_q == 3'd0));

  assert_flush_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(srst_wr));

  assert_sleep_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_sleep) |-> $past(flag_config || (flag_normal && !flag_snoop)));

  assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_sleep) |-> (flag_config || (flag_normal && !flag_snoop)));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_config, flag_sleep, flag_normal}));

  assert_snoop_in_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_snoop |-> (flag_normal && mode_code == 3'd4));

  assert_loopback_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3) |-> !(flag_config || flag_sleep || flag_normal));

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock != flag_config);

  assert_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr_ok |-> flag_config);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(mode_code));
endmodule

bind can_mode_seq cms_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR)
) u_cms_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .guard_wr_ok(guard_wr_ok), .cfg_lock(cfg_lock),
  .flush_pulse(flush_pulse), .flag_config(flag_config), .flag_sleep(flag_sleep),
  .flag_normal(flag_normal), .flag_snoop(flag_snoop), .mode_code(mode_code),
  .msel_q(msel_q)
);

// File: tb/test_can_mode_seq.sv
`timescale 1ns/1ps
module test_can_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [0:0] reg_addr = '0;
  logic [2:0] reg_wdata = '0;
  logic       guard_wr_req = 1'b0;
  logic       guard_wr_ok, cfg_lock, flush_pulse;
  logic       flag_config, flag_sleep, flag_normal, flag_snoop;
  logic [2:0] mode_code, msel_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [2:0] C_CFG = 3'd0, C_SLP = 3'd1, C_NRM = 3'd2, C_LBK = 3'd3, C_SNP = 3'd4;

  always #4 clk = ~clk;

  can_mode_seq i_can_mode_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .guard_wr_req(guard_wr_req), .guard_wr_ok(guard_wr_ok),
    .cfg_lock(cfg_lock), .flush_pulse(flush_pulse), .flag_config(flag_config),
    .flag_sleep(flag_sleep), .flag_normal(flag_normal), .flag_snoop(flag_snoop),
    .mode_code(mode_code), .msel_q(msel_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Write one register; returns at the negedge after the capturing edge.
  task automatic wr(input logic [0:0] a, input logic [2:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic expect_mode(input logic [2:0] exp, input string tag);
    logic [3:0] f, ef;
    f = {flag_config, flag_sleep, flag_normal, flag_snoop};
    case (exp)
      C_CFG:   ef = 4'b1000;
      C_SLP:   ef = 4'b0100;
      C_NRM:   ef = 4'b0010;
      C_SNP:   ef = 4'b0011;
      default: ef = 4'b0000;
    endcase
    chk(mode_code == exp, {tag, " R8 code"}, mode_code, exp);
    chk(f == ef, {tag, " R8 flags"}, f, ef);
    chk(cfg_lock == (exp != C_CFG), {tag, " R9 lock"}, cfg_lock, exp != C_CFG);
  endtask

  task automatic go_config();
    wr(0, 3'b000);
  endtask

  task automatic enter(input logic [2:0] sel);
    go_config();
    wr(1, sel);
    wr(0, 3'b010);
  endtask

  task automatic t_reset();
    expect_mode(C_CFG, "R1 hw reset");
    chk(msel_q == 3'd0, "R1 msel after reset", msel_q, 0);
    chk(flush_pulse == 1'b0, "R1 no flush at reset", flush_pulse, 0);
  endtask

  task automatic t_enter_each();
    enter(3'b000); expect_mode(C_NRM, "R4 normal");
    enter(3'b001); expect_mode(C_SLP, "R4 sleep");
    enter(3'b010); expect_mode(C_LBK, "R4 loopback");
    enter(3'b100); expect_mode(C_SNP, "R4 snoop");
    chk(msel_q == 3'b100, "R3 msel stored", msel_q, 4);
    go_config(); expect_mode(C_CFG, "R2 snoop to config");
  endtask

  task automatic t_multi();
    enter(3'b011); expect_mode(C_CFG, "R5 two bits");
    enter(3'b111); expect_mode(C_CFG, "R5 three bits");
  endtask

  task automatic t_swap();
    enter(3'b000);
    wr(1, 3'b001); expect_mode(C_SLP, "R6 normal to sleep");
    chk(msel_q == 3'b001, "R6 msel sleep", msel_q, 1);
    wr(1, 3'b000); expect_mode(C_NRM, "R6 sleep to normal");
    chk(msel_q == 3'b000, "R6 msel zero", msel_q, 0);
  endtask

  task automatic t_ignored();
    enter(3'b010);
    wr(1, 3'b001); expect_mode(C_LBK, "R7 loopback ignores sleep");
    chk(msel_q == 3'b010, "R7 msel kept", msel_q, 2);
    wr(0, 3'b010); expect_mode(C_LBK, "R7 enable again ignored");
    enter(3'b000);
    wr(1, 3'b100); expect_mode(C_NRM, "R7 normal ignores snoop");
    chk(msel_q == 3'b000, "R7 msel kept normal", msel_q, 0);
    enter(3'b100);
    wr(1, 3'b001); expect_mode(C_SNP, "R7 snoop ignores sleep");
    enter(3'b001);
    wr(1, 3'b010); expect_mode(C_SLP, "R7 sleep ignores loopback");
    chk(msel_q == 3'b001, "R7 msel kept sleep", msel_q, 1);
  endtask

  task automatic t_softreset();
    enter(3'b100);
    wr(0, 3'b011);
    expect_mode(C_CFG, "R1 soft reset wins");
    chk(flush_pulse == 1'b1, "R1 flush high", flush_pulse, 1);
    chk(msel_q == 3'b000, "R1 msel cleared", msel_q, 0);
    @(negedge clk);
    chk(flush_pulse == 1'b0, "R1 flush one cycle", flush_pulse, 0);
  endtask

  task automatic t_guard();
    go_config();
    guard_wr_req = 1'b1; #1;
    chk(guard_wr_ok == 1'b1, "R9 guard open in config", guard_wr_ok, 1);
    enter(3'b000); #1;
    chk(guard_wr_ok == 1'b0, "R9 guard shut in normal", guard_wr_ok, 0);
    guard_wr_req = 1'b0;
  endtask

  task automatic t_timing();
    go_config();
    wr(1, 3'b001);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 0; reg_wdata = 3'b010;
    #1;
    chk(mode_code == C_CFG, "R10 before edge", mode_code, C_CFG);
    @(negedge clk);
    reg_wr = 1'b0;
    chk(mode_code == C_SLP, "R10 after edge", mode_code, C_SLP);
    repeat (3) @(negedge clk);
    chk(mode_code == C_SLP, "R10 held", mode_code, C_SLP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enter_each();
    t_multi();
    t_swap();
    t_ignored();
    t_softreset();
    t_guard();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule